// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block adds two unsigned binary operands of `WIDTH` bits and a carry-in. It returns the `WIDTH`-bit sum and the carry-out one clock later. The adder works without a ripple chain. Each bit position forms a generate term (both operand bits set) and a transmit term (either operand bit set). Four bit positions combine into a block term, and four blocks combine into a super-block term, so every lookahead stage has the same fan-in of four. A final stage spans the super-blocks and takes the carry-in.

Carries come down the tree only at every second bit. Each carry feeds a two-bit sum slice. In the slice, the incoming carry selects between two prepared versions of the lower sum bit. The upper sum bit is formed in advance from both operand pairs of the slice, so a carry generated in the lower bit is already counted. That upper bit is inverted only when the incoming carry passes through the lower bit, which happens when exactly one of the two lower operand bits is set.

The sum and carry-out are held in output registers with a synchronous, active-high reset. The block is meant to sit as a pipelined add stage in a wider datapath.

Top module: `bca_adder`

## Requirements
- R1: On every clock edge with `rst` low, `sum` takes the low `WIDTH` bits of `x + y + cin` as sampled at that edge, so the result appears one clock after the inputs.
- R2: `cout` takes bit `WIDTH` of the same `x + y + cin`, the carry out of the most significant position, at the same edge as `sum`.
- R3: When `rst` is high at a clock edge, `sum` becomes all zeros and `cout` becomes 0 at that edge, whatever the operand inputs are.
- R4: With `x` all ones and `cin` = 1, the carry passes the full width: `cout` = 1 and `sum` equals `y`.
- R5: When `x` and `y` are bitwise complements (for example 0xAAAA... and 0x5555...), `sum` is all ones and `cout` = 0 for `cin` = 0, and `sum` is all zeros and `cout` = 1 for `cin` = 1.
- R6: A carry generated at bit 0 (`x` = 1, `y` all ones, `cin` = 0) travels through every block and super-block: `sum` is zero and `cout` = 1.
- R7: With `x` = `y` = a single set bit at position k, for every k from 0 to `WIDTH`-1, `sum` has only bit k+1 set, and `cout` = 1 only for k = `WIDTH`-1. This covers carries that cross block and super-block edges.
- R8: Each two-bit slice gives the correct pair of sum bits for all sixteen pairs of its operand bits, with an incoming carry of 0 and of 1. This includes the case where the upper bit must be inverted because the carry passes the lower bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs update on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| x | input | WIDTH | First operand |
| y | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Registered sum, low `WIDTH` bits |
| cout | output | 1 | Registered carry out of bit `WIDTH`-1 |

## Verification
The slice sweep holds every bit below one slice at a transmit value with `cin` chosen, which delivers a known carry into that slice. It then walks all operand pairs across it, so a wrong selection or a missing upper-bit inversion in any one slice shows up on its own. Single set bits at every position separate tree faults at block and super-block edges from slice faults. All-ones and complementary operands force the longest transmit chain and expose a tree built with exclusive-OR where inclusive-OR belongs, or the reverse. Random operands cover the mixed generate and transmit patterns that none of the targeted vectors reach.

// File: rtl/bca_pkg.sv
package bca_pkg;
  // fan-in of every lookahead stage (bits per block, blocks per super-block)
  localparam int BCA_FANIN = 4;
  // bits handled by one sum slice; carries are produced at this pitch
  localparam int BCA_SLICE = 2;
endpackage

// File: rtl/bca_bitgen.sv
module bca_bitgen #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] xmit
);
  // generate: both set; transmit: inclusive OR (not exclusive)
  always_comb begin
    gen  = a & b;
    xmit = a | b;
  end
endmodule

// File: rtl/bca_la_cell.sv
module bca_la_cell #(
  parameter int N      = 4,
  parameter int STRIDE = 1
) (
  input  logic [N-1:0]        gen,
  input  logic [N-1:0]        xmit,
  input  logic                cin,
  output logic                grp_gen,
  output logic                grp_xmit,
  output logic [N/STRIDE-1:0] child_c
);
  localparam int NOUT = N / STRIDE;

  // group terms: do not depend on the incoming carry
  always_comb begin
    logic gacc;
    logic pacc;
    gacc = 1'b0;
    pacc = 1'b1;
    for (int i = 0; i < N; i++) begin
      gacc = gen[i] | (xmit[i] & gacc);
      pacc = pacc & xmit[i];
    end
    grp_gen  = gacc;
    grp_xmit = pacc;
  end

  // carries into children at the chosen pitch; flattens to sum of products
  always_comb begin
    for (int k = 0; k < NOUT; k++) begin
      logic c;
      c = cin;
      for (int j = 0; j < k * STRIDE; j++) begin
        c = gen[j] | (xmit[j] & c);
      end
      child_c[k] = c;
    end
  end
endmodule

// File: rtl/bca_slice.sv
module bca_slice (
  input  logic [1:0] a,
  input  logic [1:0] b,
  input  logic       c,
  output logic [1:0] s
);
  logic dif_lo;   // carry passes the lower bit
  logic gen_lo;   // carry born in the lower bit
  logic dif_hi;
  logic lo_c0, lo_c1;
  logic hi_pre;

  always_comb begin
    dif_lo = a[0] ^ b[0];
    gen_lo = a[0] & b[0];
    dif_hi = a[1] ^ b[1];
    // lower bit: two prepared versions, picked by the carry
    lo_c0  = dif_lo;
    lo_c1  = ~dif_lo;
    s[0]   = c ? lo_c1 : lo_c0;
    // upper bit: formed from both pairs, corrected only on pass-through
    hi_pre = dif_hi ^ gen_lo;
    s[1]   = hi_pre ^ (c & dif_lo);
  end
endmodule

// File: rtl/bca_adder.sv
module bca_adder
  import bca_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NBLK = WIDTH / BCA_FANIN;
  localparam int NSUP = NBLK / BCA_FANIN;
  localparam int NSLC = WIDTH / BCA_SLICE;
  localparam int CPB  = BCA_FANIN / BCA_SLICE;  // slice carries per block

  logic [WIDTH-1:0] bit_g, bit_p;
  logic [NBLK-1:0]  blk_g, blk_p, blk_c;
  logic [NSUP-1:0]  sup_g, sup_p, sup_c;
  logic [NSLC-1:0]  slc_c;
  logic             top_g, top_p;
  logic [WIDTH-1:0] sum_d;
  logic             cout_d;

  bca_bitgen #(.WIDTH(WIDTH)) u_bits (
    .a(x), .b(y), .gen(bit_g), .xmit(bit_p)
  );

  // level 1: four bits per block, carries every second bit
  for (genvar bk = 0; bk < NBLK; bk++) begin : g_blk
    bca_la_cell #(.N(BCA_FANIN), .STRIDE(BCA_SLICE)) u_cell (
      .gen     (bit_g[bk*BCA_FANIN +: BCA_FANIN]),
      .xmit    (bit_p[bk*BCA_FANIN +: BCA_FANIN]),
      .cin     (blk_c[bk]),
      .grp_gen (blk_g[bk]),
      .grp_xmit(blk_p[bk]),
      .child_c (slc_c[bk*CPB +: CPB])
    );
  end

  // level 2: four blocks per super-block
  for (genvar sb = 0; sb < NSUP; sb++) begin : g_sup
    bca_la_cell #(.N(BCA_FANIN), .STRIDE(1)) u_cell (
      .gen     (blk_g[sb*BCA_FANIN +: BCA_FANIN]),
      .xmit    (blk_p[sb*BCA_FANIN +: BCA_FANIN]),
      .cin     (sup_c[sb]),
      .grp_gen (sup_g[sb]),
      .grp_xmit(sup_p[sb]),
      .child_c (blk_c[sb*BCA_FANIN +: BCA_FANIN])
    );
  end

  // top stage: spans the super-blocks and takes the carry-in
  bca_la_cell #(.N(NSUP), .STRIDE(1)) u_top (
    .gen     (sup_g),
    .xmit    (sup_p),
    .cin     (cin),
    .grp_gen (top_g),
    .grp_xmit(top_p),
    .child_c (sup_c)
  );

  assign cout_d = top_g | (top_p & cin);

  for (genvar sl = 0; sl < NSLC; sl++) begin : g_slc
    bca_slice u_slice (
      .a(x[sl*BCA_SLICE +: BCA_SLICE]),
      .b(y[sl*BCA_SLICE +: BCA_SLICE]),
      .c(slc_c[sl]),
      .s(sum_d[sl*BCA_SLICE +: BCA_SLICE])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= sum_d;
      cout <= cout_d;
    end
  end
endmodule

// File: rtl/bca_adder_chk.sv
module bca_adder_chk #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] x,
  input logic [WIDTH-1:0] y,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout
);
  logic             armed;     // previous edge was out of reset
  logic             was_rst;   // previous edge was in reset
  logic [WIDTH:0]   model_q;   // arithmetic model of the last sampled inputs

  always_ff @(posedge clk) begin
    armed   <= !rst;
    was_rst <= rst;
    model_q <= {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  end

  p_sum_r1: assert property (@(posedge clk) disable iff (rst)
    armed |-> sum == model_q[WIDTH-1:0]);

  p_carry_out_r2: assert property (@(posedge clk) disable iff (rst)
    armed |-> cout == model_q[WIDTH]);

  p_reset_clear_r3: assert property (@(posedge clk) disable iff (rst)
    was_rst |-> (sum == '0) && !cout);

  p_full_chain_r4: assert property (@(posedge clk) disable iff (rst)
    armed && $past(&x) && $past(cin) |-> cout && (sum == $past(y)));

  p_complement_r5: assert property (@(posedge clk) disable iff (rst)
    armed && $past(&(x ^ y)) |->
      (cout == $past(cin)) && (sum == ($past(cin) ? '0 : '1)));
endmodule

bind bca_adder bca_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .x(x), .y(y), .cin(cin), .sum(sum), .cout(cout)
);

// File: tb/bca_adder_bench.sv
module bca_adder_bench;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] x   = '0;
  logic [W-1:0] y   = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bca_adder #(.WIDTH(W)) u_bca_adder (
    .clk(clk), .rst(rst), .x(x), .y(y), .cin(cin), .sum(sum), .cout(cout)
  );

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; result is checked at the next falling edge
  task automatic apply(input string req, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic c);
    logic [W:0] exp;
    x = a; y = b; cin = c;
    exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    @(posedge clk);
    @(negedge clk);
    check(req, {cout, sum}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ones;
    logic [W-1:0] alt;
    ones = '1;
    alt  = {(W/2){2'b10}};

    // R3: reset state, and reset wins over live operands
    repeat (3) @(negedge clk);
    check("R3 reset state", {cout, sum}, '0);
    x = ones; y = ones; cin = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R3 reset dominant", {cout, sum}, '0);
    rst = 1'b0;

    // R2: carry-out cases
    apply("R2 max plus max", ones, ones, 1'b1);
    apply("R2 top bits", {1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, 1'b0);
    apply("R2 no carry", ones, '0, 1'b0);

    // R4: all-ones chain with carry-in
    apply("R4 ones plus zero", ones, '0, 1'b1);
    for (int i = 0; i < 8; i++)
      apply("R4 ones plus random", ones, {$urandom(), $urandom()}, 1'b1);

    // R5: complementary operands
    apply("R5 alt cin0", alt, ~alt, 1'b0);
    apply("R5 alt cin1", alt, ~alt, 1'b1);
    apply("R5 alt swapped", ~alt, alt, 1'b1);
    for (int i = 0; i < 8; i++) begin
      logic [W-1:0] r;
      r = {$urandom(), $urandom()};
      apply("R5 random complement", r, ~r, i[0]);
    end

    // R6: carry born at bit 0 runs the whole width
    apply("R6 generate at bit0", {{(W-1){1'b0}}, 1'b1}, ones, 1'b0);

    // R7: single set bit doubled at every position
    for (int k = 0; k < W; k++) begin
      logic [W-1:0] v;
      v = '0;
      v[k] = 1'b1;
      apply("R7 single bit double", v, v, 1'b0);
    end

    // R8: every slice, all operand pairs, incoming carry 0 and 1
    for (int s = 0; s < W/2; s++) begin
      for (int v = 0; v < 32; v++) begin
        logic [W-1:0] low, a, b;
        low = (W'(1) << (2*s)) - W'(1);
        a = (W'(v & 3) << (2*s)) | low;
        b = W'((v >> 2) & 3) << (2*s);
        apply("R8 slice sweep", a, b, v[4]);
      end
    end

    // R1: random operands
    for (int i = 0; i < 1500; i++)
      apply("R1 random", {$urandom(), $urandom()}, {$urandom(), $urandom()}, $urandom() & 1);

    // R3: mid-run reset with live operands
    x = ones; y = alt; cin = 1'b1;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R3 mid-run reset", {cout, sum}, '0);
    rst = 1'b0;
    apply("R1 after reset", ones, alt, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule